// File: doc/BRIEF.md
# Flash Program/Erase Status Responder

This block is a device-side controller that makes a small byte-wide register file behave like a flash array with built-in program and erase algorithms. A host issues one-cycle commands on a simple command port: program one byte, erase one sector, or erase the whole array. Each accepted command runs for a fixed, parameterised number of clock cycles. During that time an active-low ready/busy output is held low, and any other command is dropped.

While an operation runs, or after one has failed, a read that falls in the affected region returns a status word instead of stored data. The top data bit is a polling flag and a lower bit is an error flag. Reads outside that region keep returning array contents. The host polls the status word until the polling flag matches the bit it wrote, and it checks the error flag to detect a failure. An erase fills its region with all-ones bytes. A program can only clear bits, so an attempt to raise a cleared bit is reported as an error after a timeout period. A fault input that is sampled when an erase command is accepted models an erase that never verifies.

Top module: `flash_status_responder`

## Requirements
- R1: After reset every byte reads FFh, rb_n is 1 and no status is shown.
- R2: A program command (cmd_op=01) that only clears bits holds rb_n low for exactly PROG_CYC cycles, starting the cycle after it is accepted. Afterwards the byte holds old AND new, and reads return plain data.
- R3: While a program runs, a read of the target address returns a word whose bit 7 is the inverse of bit 7 of the written data, with every other bit 0. A read of any other address returns stored data.
- R4: A program that asks for any 0-to-1 bit change keeps rb_n low for TIMEOUT_CYC cycles and stores old AND new. After that, reads of the target return bit 5 = 1 and bit 7 = stored bit 7, all other bits 0, while rb_n is 1.
- R5: A sector erase (cmd_op=10, sector = top SECT_W address bits) takes ERASE_CYC cycles. It sets every byte of that sector to FFh and leaves the other sectors unchanged.
- R6: While an erase runs, every read inside the erased region returns 00h.
- R7: A whole-array erase (cmd_op=11) takes ERASE_CYC cycles and sets every byte to FFh.
- R8: An erase accepted with cmd_fault=1 takes TIMEOUT_CYC cycles and leaves the array unchanged. Afterwards reads inside its region return 20h (bit 5 set, bit 7 clear).
- R9: A command that arrives while rb_n is 0 is ignored. It neither extends the operation nor changes the array.
- R10: The error status stays visible until the next accepted command (cmd_op not 00), which clears it. A valid command with cmd_op=00 is not accepted and clears nothing.
- R11: When a failing operation finishes, bit 7 takes its final value in the same cycle that bit 5 becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 00 none, 01 program, 10 sector erase, 11 array erase |
| cmd_addr | input | ADDR_W | Target byte or sector address |
| cmd_data | input | DATA_W | Program data |
| cmd_fault | input | 1 | Erase fault injection, sampled when the command is accepted |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Stored data or status word (combinational) |
| rb_n | output | 1 | Ready/busy, 0 while an operation runs |

## Verification
Two events can fall on the same cycle: the operation finishing and the error flag being raised, both of which change the status word a poller reads. The bench sets up failing programs, including one whose failure involves bit 7 itself, and faulty erases. It reads the target on the last busy cycle and again on the first idle cycle, and expects bit 5 to be clear in the first read and set in the second, while bit 7 moves from its busy value to its final value in the same step. A chip-erase command injected in the middle of a program shows whether completion and an arriving command are kept apart.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_PROG = 2'd1,
      OP_SECT = 2'd2,
      OP_ALL  = 2'd3
   } fsr_op_e;
endpackage

// File: rtl/fsr_seq.sv
module fsr_seq
   import fsr_pkg::*;
#(
   parameter int PROG_CYC    = 3,
   parameter int ERASE_CYC   = 5,
   parameter int TIMEOUT_CYC = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [1:0] cmd_op,
   input  logic       will_fail,
   output logic       accept,
   output logic       busy_q,
   output logic       finish,
   output logic       err_q,
   output logic       fail_q,
   output fsr_op_e    op_q
);
   localparam int MAX_A   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
   localparam int MAX_CYC = (TIMEOUT_CYC > MAX_A) ? TIMEOUT_CYC : MAX_A;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;

   assign accept = cmd_valid && !busy_q && (cmd_op != OP_NONE);
   assign finish = busy_q && (cnt_q == CNT_W'(1));

   always_comb begin
      if (will_fail)                load_val = CNT_W'(TIMEOUT_CYC);
      else if (cmd_op == OP_PROG)   load_val = CNT_W'(PROG_CYC);
      else                          load_val = CNT_W'(ERASE_CYC);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         err_q  <= 1'b0;
         fail_q <= 1'b0;
         cnt_q  <= '0;
         op_q   <= OP_NONE;
      end else if (accept) begin
         busy_q <= 1'b1;
         err_q  <= 1'b0;
         fail_q <= will_fail;
         cnt_q  <= load_val;
         op_q   <= fsr_op_e'(cmd_op);
      end else if (busy_q) begin
         if (finish) begin
            busy_q <= 1'b0;
            err_q  <= fail_q;
         end else begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/fsr_array.sv
module fsr_array #(
   parameter int ADDR_W = 5,
   parameter int SECT_W = 2,
   parameter int DATA_W = 8,
   parameter int NRD    = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          prog_en,
   input  logic                          sect_en,
   input  logic                          all_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic [NRD-1:0][ADDR_W-1:0]    rd_addr,
   output logic [NRD-1:0][DATA_W-1:0]    rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
      logic hit_sect;
      assign hit_sect = (IDX[ADDR_W-1 -: SECT_W] == wr_addr[ADDR_W-1 -: SECT_W]);
      always_ff @(posedge clk) begin
         if (!rst_n)
            mem[i] <= '1;
         else if (all_en || (sect_en && hit_sect))
            mem[i] <= '1;
         else if (prog_en && (wr_addr == IDX))
            mem[i] <= mem[i] & wr_data;
      end
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rd_data[r] = mem[rd_addr[r]];
   end
endmodule

// File: rtl/fsr_rdmux.sv
module fsr_rdmux
   import fsr_pkg::*;
#(
   parameter int ADDR_W  = 5,
   parameter int SECT_W  = 2,
   parameter int DATA_W  = 8,
   parameter int ERR_BIT = 5
) (
   input  logic              busy,
   input  logic              err,
   input  fsr_op_e           op_q,
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic              tgt_new7,
   input  logic              tgt_stored7,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] arr_data,
   output logic [DATA_W-1:0] rd_data
);
   localparam int MSB = DATA_W - 1;

   logic              in_reg;
   logic              poll7;
   logic [DATA_W-1:0] status;

   always_comb begin
      case (op_q)
         OP_PROG: in_reg = (rd_addr == tgt_addr);
         OP_SECT: in_reg = (rd_addr[ADDR_W-1 -: SECT_W] == tgt_addr[ADDR_W-1 -: SECT_W]);
         OP_ALL:  in_reg = 1'b1;
         default: in_reg = 1'b0;
      endcase
      if (op_q == OP_PROG) poll7 = busy ? ~tgt_new7 : tgt_stored7;
      else                 poll7 = 1'b0;
      status          = '0;
      status[MSB]     = poll7;
      status[ERR_BIT] = err;
      rd_data = ((busy || err) && in_reg) ? status : arr_data;
   end
endmodule

// File: rtl/flash_status_responder.sv
module flash_status_responder
   import fsr_pkg::*;
#(
   parameter int ADDR_W      = 5,
   parameter int SECT_W      = 2,
   parameter int DATA_W      = 8,
   parameter int ERR_BIT     = 5,
   parameter int PROG_CYC    = 3,
   parameter int ERASE_CYC   = 5,
   parameter int TIMEOUT_CYC = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic              cmd_fault,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rb_n
);
   localparam int NRD = 3;
   localparam int MSB = DATA_W - 1;

   if (SECT_W < 1 || SECT_W >= ADDR_W) begin : g_bad_sect
      $error("SECT_W must lie in 1..ADDR_W-1");
   end
   if (ERR_BIT < 0 || ERR_BIT >= MSB) begin : g_bad_err
      $error("ERR_BIT must be below the polling bit");
   end
   if (PROG_CYC < 1 || ERASE_CYC < 1 || TIMEOUT_CYC < 1) begin : g_bad_cyc
      $error("cycle counts must be at least 1");
   end

   logic                       accept, busy_q, finish, err_q, fail_q, will_fail;
   fsr_op_e                    op_q;
   logic [ADDR_W-1:0]          tgt_addr_q;
   logic [DATA_W-1:0]          tgt_data_q;
   logic [NRD-1:0][ADDR_W-1:0] ra;
   logic [NRD-1:0][DATA_W-1:0] rv;
   logic                       prog_en, sect_en, all_en;

   assign ra        = {tgt_addr_q, rd_addr, cmd_addr};
   assign will_fail = (cmd_op == OP_PROG) ? |(~rv[0] & cmd_data) : cmd_fault;

   fsr_seq #(
      .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
   ) i_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .will_fail(will_fail), .accept(accept), .busy_q(busy_q),
      .finish(finish), .err_q(err_q), .fail_q(fail_q), .op_q(op_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_addr_q <= '0;
         tgt_data_q <= '0;
      end else if (accept) begin
         tgt_addr_q <= cmd_addr;
         tgt_data_q <= cmd_data;
      end
   end

   assign prog_en = finish && (op_q == OP_PROG);
   assign sect_en = finish && (op_q == OP_SECT) && !fail_q;
   assign all_en  = finish && (op_q == OP_ALL)  && !fail_q;

   fsr_array #(
      .ADDR_W(ADDR_W), .SECT_W(SECT_W), .DATA_W(DATA_W), .NRD(NRD)
   ) i_array (
      .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .sect_en(sect_en),
      .all_en(all_en), .wr_addr(tgt_addr_q), .wr_data(tgt_data_q),
      .rd_addr(ra), .rd_data(rv)
   );

   fsr_rdmux #(
      .ADDR_W(ADDR_W), .SECT_W(SECT_W), .DATA_W(DATA_W), .ERR_BIT(ERR_BIT)
   ) i_rdmux (
      .busy(busy_q), .err(err_q), .op_q(op_q), .tgt_addr(tgt_addr_q),
      .tgt_new7(tgt_data_q[MSB]), .tgt_stored7(rv[2][MSB]),
      .rd_addr(rd_addr), .arr_data(rv[1]), .rd_data(rd_data)
   );

   assign rb_n = ~busy_q;
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
   parameter int ADDR_W      = 5,
   parameter int SECT_W      = 2,
   parameter int DATA_W      = 8,
   parameter int PROG_CYC    = 3,
   parameter int ERASE_CYC   = 5,
   parameter int TIMEOUT_CYC = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [1:0]        cmd_op,
   input logic              rb_n,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic              err_q,
   input logic [1:0]        op_q,
   input logic [ADDR_W-1:0] tgt_addr_q
);
   localparam int MAX_A   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
   localparam int MAX_CYC = (TIMEOUT_CYC > MAX_A) ? TIMEOUT_CYC : MAX_A;
   localparam int BC_W    = $clog2(MAX_CYC + 2);

   logic [BC_W-1:0] bcnt;
   logic            in_erase_reg;

   always_ff @(posedge clk) begin
      if (!rst_n || rb_n) bcnt <= '0;
      else                bcnt <= bcnt + BC_W'(1);
   end

   assign in_erase_reg = (op_q == 2'd3) ||
      ((op_q == 2'd2) && (rd_addr[ADDR_W-1 -: SECT_W] == tgt_addr_q[ADDR_W-1 -: SECT_W]));

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && rb_n && (cmd_op != 2'd0) |=> !rb_n);                 // R2
   AST_NOP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && rb_n && (cmd_op == 2'd0) |=> rb_n);                  // R10
   AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      !rb_n |-> (bcnt < BC_W'(MAX_CYC)));                               // R4
   AST_ERR_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> rb_n);                                                  // R4
   AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && rb_n && (cmd_op != 2'd0) |=> !err_q);                // R10
   AST_FLAG_RACE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> $rose(rb_n));                                    // R11
   AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !rb_n && in_erase_reg |-> !rd_data[DATA_W-1]);                    // R6
endmodule

bind flash_status_responder fsr_checker #(
   .ADDR_W(ADDR_W), .SECT_W(SECT_W), .DATA_W(DATA_W),
   .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_fsr_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .rb_n(rb_n), .rd_addr(rd_addr), .rd_data(rd_data), .err_q(err_q),
   .op_q(op_q), .tgt_addr_q(tgt_addr_q)
);

// File: tb/test_flash_status_responder.sv
module test_flash_status_responder;
   localparam int AW = 5, SW = 2, DW = 8;
   localparam int PC = 3, EC = 5, TC = 7;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = 2'd0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_data = '0;
   logic          cmd_fault = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          rb_n;

   always #10 clk = ~clk;

   flash_status_responder #(
      .ADDR_W(AW), .SECT_W(SW), .DATA_W(DW), .ERR_BIT(5),
      .PROG_CYC(PC), .ERASE_CYC(EC), .TIMEOUT_CYC(TC)
   ) i_flash_status_responder (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_fault(cmd_fault),
      .rd_addr(rd_addr), .rd_data(rd_data), .rb_n(rb_n)
   );

   int            nvec = 0, nbad = 0;
   logic [DW-1:0] mem [DEPTH];
   logic          err_hold = 1'b0;
   logic [1:0]    err_op = 2'd0;
   logic [AW-1:0] err_tgt = '0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic in_region(logic [1:0] op, logic [AW-1:0] t, logic [AW-1:0] a);
      case (op)
         2'd1:    return a == t;
         2'd2:    return a[AW-1 -: SW] == t[AW-1 -: SW];
         2'd3:    return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a);
      if (err_hold && in_region(err_op, err_tgt, a))
         return (err_op == 2'd1) ? ((mem[err_tgt] & 8'h80) | 8'h20) : 8'h20;
      return mem[a];
   endfunction

   task automatic sweep(string req);
      for (int a = 0; a < DEPTH; a++) begin
         rd_addr = AW'(a);
         #1;
         chk(req, rd_data, exp_read(AW'(a)));
      end
   endtask

   // issue one command, follow it while busy, then update the model
   task automatic run_op(logic [1:0] op, logic [AW-1:0] ad, logic [DW-1:0] d,
                         logic fault, logic inject, string req);
      logic          fail;
      int            n, k;
      logic [DW-1:0] bstat;
      logic [AW-1:0] other;
      fail = (op == 2'd1) ? |(~mem[ad] & d) : fault;
      n    = fail ? TC : ((op == 2'd1) ? PC : EC);
      bstat = (op == 2'd1) ? ((~d) & 8'h80) : 8'h00;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = ad; cmd_data = d; cmd_fault = fault;
      @(negedge clk);
      cmd_valid = 1'b0;
      err_hold  = 1'b0;
      k = 0;
      while (!rb_n && k < 40) begin
         cmd_valid = 1'b0;
         rd_addr = ad;
         #1;
         chk((op == 2'd1) ? "R3 busy poll target" : "R6 busy erase status", rd_data, bstat);
         other = ad + AW'(11 + k);
         rd_addr = other;
         #1;
         chk((op == 2'd1) ? "R3 other address" : "R6 erase region read", rd_data,
             in_region(op, ad, other) ? bstat : mem[other]);
         if (inject && k == 1) begin
            cmd_valid = 1'b1; cmd_op = 2'd3; cmd_fault = 1'b0; // R9 ignored while busy
         end
         k++;
         @(negedge clk);
      end
      cmd_valid = 1'b0;
      chk({req, " busy length"}, k, n);
      if (op == 2'd1) mem[ad] = mem[ad] & d;
      else if (!fail)
         for (int a = 0; a < DEPTH; a++)
            if (in_region(op, ad, AW'(a))) mem[a] = 8'hFF;
      err_hold = fail; err_op = op; err_tgt = ad;
      rd_addr = ad;
      #1;
      chk("R11 first idle read of target", rd_data, exp_read(ad));
      chk("R11 ready after finish", rb_n, 1'b1);
      sweep(req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      for (int a = 0; a < DEPTH; a++) mem[a] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after reset", rb_n, 1'b1);
      sweep("R1 reset contents");

      for (int a = 0; a < DEPTH; a++)
         run_op(2'd1, AW'(a), DW'(a * 29 + 7), 1'b0, 1'b0, "R2 program");

      run_op(2'd1, AW'(5), 8'hFF, 1'b0, 1'b0, "R4 program raise bits");
      run_op(2'd1, AW'(0), 8'h87, 1'b0, 1'b0, "R4 program raise bit7");

      // R10: a no-op strobe is not accepted and keeps the error status
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'd0;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R10 no-op leaves ready", rb_n, 1'b1);
      sweep("R10 error kept after no-op");

      run_op(2'd1, AW'(1), 8'h04, 1'b0, 1'b0, "R10 next command clears error");
      run_op(2'd1, AW'(2), 8'h01, 1'b0, 1'b1, "R9 command while busy");
      run_op(2'd2, AW'(8), 8'h00, 1'b0, 1'b0, "R5 sector erase");
      run_op(2'd2, AW'(17), 8'h00, 1'b1, 1'b0, "R8 sector erase fault");
      run_op(2'd2, AW'(30), 8'h00, 1'b0, 1'b1, "R5 sector erase last");
      run_op(2'd1, AW'(9), 8'h3C, 1'b0, 1'b0, "R2 program after erase");
      run_op(2'd3, AW'(0), 8'h00, 1'b1, 1'b0, "R8 array erase fault");
      run_op(2'd1, AW'(9), 8'h00, 1'b0, 1'b0, "R10 clear after erase fault");
      run_op(2'd3, AW'(4), 8'h00, 1'b0, 1'b0, "R7 array erase");
      run_op(2'd1, AW'(31), 8'h7F, 1'b0, 1'b0, "R3 program bit7 clear");

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule